// File: doc/BRIEF.md
# Sign-Bit Phase Accumulator Pulse Channel

This block is one counter channel on a simple register bus. It holds a phase accumulator, an increment register and a control word. On every clock the accumulator adds the increment to itself, and the sum wraps around. When the control word selects the numerically-controlled-oscillator mode, the sign bit of the accumulator drives one output pin, and the control word also picks which pin that is.

A bus write to the phase register replaces that cycle's accumulation. Software can therefore make a one-shot pulse of exact width. It sets the increment to one, then writes minus N into the phase. The pin goes high on the next edge and stays high for exactly N clocks, until the accumulator reaches zero. After that the accumulator has to climb through half its range before the sign bit sets again, so software has ample time to clear the increment. The phase can be read back at all times.

Top module: `phase_pulse_counter`

## Requirements
- R1: While reset is high and after it is released, the phase readback, every pin output and every pin output enable are zero, and so are the increment and the control word.
- R2: On each clock without a phase write, the accumulator becomes its previous value plus the increment register, modulo 2^32.
- R3: A write to the phase register loads exactly the written value on that edge, and no increment is added. The new value is visible on the phase readback after that edge.
- R4: Control bits 30:26 hold the mode, and bits 4:0 hold the pin number. With mode value 4 (NCO), the selected pin output equals bit 31 of the accumulator, and both update on the same clock edge.
- R5: With the increment at 1 and NCO mode active, writing minus N to the phase sets the selected pin high on the write edge. The pin then stays high for exactly N clocks.
- R6: With the increment at 0 the phase holds its value. With the increment at all-ones the phase drops by one each clock.
- R7: With any mode value other than 4 (including 0, off), all pin outputs and output enables are zero, and the accumulator keeps updating.
- R8: In NCO mode exactly one output enable is set, the one for the selected pin. Every other pin output is zero.
- R9: Write address 0 selects control, 1 selects increment and 2 selects phase. A write to address 3 changes nothing.
- R10: When the accumulator rises from 0x7FFFFFFF to 0x80000000 in NCO mode, the selected pin rises on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 control, 1 increment, 2 phase) |
| wr_data | input | 32 | Write data |
| phase_rd | output | 32 | Current accumulator value |
| pin_out | output | 32 | Pin output values, one per pin |
| pin_oe | output | 32 | Pin output enables, one per pin |

## Verification
A corrupted accumulator shows on the phase readback on the very next edge, because every cycle is either an exact load or an exact sum. A wrong sign bit or a wrong pin decode shows on pin_out or pin_oe within one clock of the control or phase write that exposed it. A pulse width that is off by one is measured directly by counting how many cycles the pin stays high, across all pins and several widths.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_INCR  = 2'd1,
    ADDR_PHASE = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;

  localparam int MODE_LSB = 26;
  localparam int MODE_W   = 5;
  localparam logic [MODE_W-1:0] MODE_OFF = 5'd0;
  localparam logic [MODE_W-1:0] MODE_NCO = 5'd4;
endpackage

// File: rtl/cnt_regs.sv
module cnt_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] ctrl_d,
  output logic [DATA_W-1:0] incr_q
);
  import cnt_pkg::*;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && wr_addr == ADDR_CTRL) ctrl_d = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      incr_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_en && wr_addr == ADDR_INCR) incr_q <= wr_data;
    end
  end
endmodule

// File: rtl/cnt_phase.sv
module cnt_phase #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] incr,
  output logic [DATA_W-1:0] phase_q,
  output logic [DATA_W-1:0] phase_d
);
  // A load overrides the sum for that cycle.
  always_comb phase_d = load ? load_val : phase_q + incr;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_d;
  end
endmodule

// File: rtl/cnt_pin_drive.sv
module cnt_pin_drive #(
  parameter int DATA_W   = 32,
  parameter int NUM_PINS = 32,
  localparam int SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   ctrl_d,
  input  logic                sign_d,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  import cnt_pkg::*;

  logic [MODE_W-1:0] mode_d;
  logic [SEL_W-1:0]  sel_d;
  logic              active_d;

  always_comb begin
    mode_d   = ctrl_d[MODE_LSB +: MODE_W];
    sel_d    = ctrl_d[SEL_W-1:0];
    active_d = (mode_d == MODE_NCO);
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit;
    always_comb hit = active_d && (sel_d == SEL_W'(p));
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[p] <= 1'b0;
        pin_oe[p]  <= 1'b0;
      end else begin
        pin_out[p] <= hit & sign_d;
        pin_oe[p]  <= hit;
      end
    end
  end
endmodule

// File: rtl/phase_pulse_counter.sv
module phase_pulse_counter #(
  parameter int DATA_W   = 32,
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   phase_rd,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  import cnt_pkg::*;

  logic [DATA_W-1:0] ctrl_q, ctrl_d, incr_q, phase_d;
  logic              phase_load;

  always_comb phase_load = wr_en && (wr_addr == ADDR_PHASE);

  cnt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .ctrl_d(ctrl_d), .incr_q(incr_q)
  );

  cnt_phase #(.DATA_W(DATA_W)) u_phase (
    .clk(clk), .rst(rst), .load(phase_load), .load_val(wr_data),
    .incr(incr_q), .phase_q(phase_rd), .phase_d(phase_d)
  );

  cnt_pin_drive #(.DATA_W(DATA_W), .NUM_PINS(NUM_PINS)) u_drive (
    .clk(clk), .rst(rst), .ctrl_d(ctrl_d), .sign_d(phase_d[DATA_W-1]),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: rtl/phase_pulse_counter_chk.sv
module phase_pulse_counter_chk #(
  parameter int DATA_W   = 32,
  parameter int NUM_PINS = 32,
  localparam int SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [1:0]          wr_addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic [DATA_W-1:0]   phase_rd,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [DATA_W-1:0]   ctrl_q,
  input logic [DATA_W-1:0]   incr_q
);
  import cnt_pkg::*;

  logic              ld;
  logic              nco;
  logic [SEL_W-1:0]  sel;
  always_comb begin
    ld  = wr_en && (wr_addr == 2'd2);
    nco = (ctrl_q[MODE_LSB +: MODE_W] == MODE_NCO);
    sel = ctrl_q[SEL_W-1:0];
  end

  // R3
  phase_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> phase_rd == $past(wr_data));

  // R2
  phase_accum_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> phase_rd == $past(phase_rd) + $past(incr_q));

  // R7
  mode_off_chk: assert property (@(posedge clk) disable iff (rst)
    !nco |-> (pin_oe == '0) && (pin_out == '0));

  // R8
  oe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pin_oe) && ((pin_out & ~pin_oe) == '0));

  // R4
  pin_sign_chk: assert property (@(posedge clk) disable iff (rst)
    nco |-> pin_oe[sel] && (pin_out[sel] == phase_rd[DATA_W-1]));
endmodule

bind phase_pulse_counter phase_pulse_counter_chk #(
  .DATA_W(DATA_W), .NUM_PINS(NUM_PINS)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .phase_rd(phase_rd), .pin_out(pin_out), .pin_oe(pin_oe),
  .ctrl_q(ctrl_q), .incr_q(incr_q)
);

// File: tb/phase_pulse_counter_bench.sv
module phase_pulse_counter_bench;
  localparam int DW = 32;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = 2'd0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] phase_rd;
  logic [NP-1:0] pin_out, pin_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  phase_pulse_counter #(.DATA_W(DW), .NUM_PINS(NP)) u_phase_pulse_counter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .phase_rd(phase_rd), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, return at the next falling edge (after the write edge).
  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] ctrl_word(input int mode, input int pin);
    return (DW'(mode) << 26) | DW'(pin);
  endfunction

  initial begin
    idle(3);
    // R1
    check("R1 phase", 64'(phase_rd), 64'd0);
    check("R1 pins", 64'(pin_out), 64'd0);
    check("R1 oe", 64'(pin_oe), 64'd0);
    rst = 1'b0;
    idle(2);
    check("R1 after release", 64'(phase_rd), 64'd0);

    // R5 R8 R4: sweep every pin with several widths
    for (int p = 0; p < NP; p++) begin
      for (int k = 0; k < 4; k++) begin
        int n;
        int cnt;
        n = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 5 : 8;
        wr(2'd1, 32'd1);
        wr(2'd2, 32'd0);
        wr(2'd0, ctrl_word(4, p));
        check("R8 oe onehot", 64'(pin_oe), 64'(1) << p);
        check("R4 low before pulse", 64'(pin_out), 64'd0);
        wr(2'd2, -DW'(n));
        cnt = 0;
        while (pin_out[p] && cnt < 100) begin
          if (pin_out != (NP'(1) << p)) check("R8 other pins", 64'(pin_out), 64'(1) << p);
          cnt++;
          @(negedge clk);
        end
        check("R5 pulse width", 64'(cnt), 64'(n));
        check("R5 phase at end", 64'(phase_rd), 64'd0);
        wr(2'd0, ctrl_word(0, 0));
      end
    end

    // R6 hold with increment 0
    wr(2'd1, 32'd0);
    wr(2'd2, 32'hCAFE_0123);
    idle(7);
    check("R6 hold", 64'(phase_rd), 64'hCAFE_0123);

    // R6 decrement with all-ones increment
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'd100);
    check("R3 load exact", 64'(phase_rd), 64'd100);
    idle(9);
    check("R6 decrement", 64'(phase_rd), 64'd91);

    // R2 general accumulation with wrap
    wr(2'd1, 32'h9000_0001);
    wr(2'd2, 32'd7);
    for (int k = 1; k <= 5; k++) begin
      logic [DW-1:0] e;
      idle(1);
      e = 32'd7 + DW'(k) * 32'h9000_0001;
      check("R2 accumulate", 64'(phase_rd), 64'(e));
    end

    // R3 load overrides accumulation with a large increment
    wr(2'd2, 32'h1234_5678);
    check("R3 override", 64'(phase_rd), 64'h1234_5678);

    // R10 sign crossing
    wr(2'd1, 32'd1);
    wr(2'd0, ctrl_word(4, 9));
    wr(2'd2, 32'h7FFF_FFFE);
    check("R10 low below", 64'(pin_out), 64'd0);
    idle(1);
    check("R10 still low", 64'(pin_out), 64'd0);
    idle(1);
    check("R10 rises", 64'(pin_out), 64'(1) << 9);
    check("R10 phase", 64'(phase_rd), 64'h8000_0000);

    // R7 off and other modes: no drive, accumulator continues
    wr(2'd0, ctrl_word(0, 9));
    check("R7 off oe", 64'(pin_oe), 64'd0);
    check("R7 off out", 64'(pin_out), 64'd0);
    idle(3);
    check("R7 accum continues", 64'(phase_rd), 64'h8000_0004);
    wr(2'd0, ctrl_word(5, 3));
    check("R7 mode5 oe", 64'(pin_oe), 64'd0);
    check("R7 mode5 out", 64'(pin_out), 64'd0);

    // R9 address 3 ignored
    wr(2'd1, 32'd0);
    wr(2'd0, ctrl_word(4, 17));
    wr(2'd2, 32'h8000_0042);
    check("R9 pin ref", 64'(pin_out), 64'(1) << 17);
    wr(2'd3, 32'h0000_0000);
    idle(2);
    check("R9 phase kept", 64'(phase_rd), 64'h8000_0042);
    check("R9 oe kept", 64'(pin_oe), 64'(1) << 17);
    check("R9 out kept", 64'(pin_out), 64'(1) << 17);

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule